// File: doc/BRIEF.md
# Channel-Windowed PRBS Bit-Error-Rate Tester

This block tests a time-division-multiplexed serial link for bit errors. A frame holds a fixed number of 8-bit channels carried one bit per bit strobe. The transmit side sends a pseudo-random binary sequence (PRBS) on the outgoing serial bit. It does so only inside a programmable window: a start channel plus a count of further channels after it. Every other channel carries idle ones. The generator freezes outside its window, so the sequence runs on from one frame to the next without a break.

The receive side takes bits only from its own window on the incoming serial bit. That window is programmed apart from the transmit window, so it may sit on a different channel or on a looped-back copy of the stream. The receiver waits until the last bits in its window match the seed value, and then declares lock. From then on it runs a local reference generator and compares each received bit against it. Every mismatch adds one to an error counter that stops at all ones.

Both sides have their own enable and share a selector for the sequence length. If the incoming stream has an input channel delay, firmware adds that delay to the receive start channel. The block takes no account of it.

Top module: `berTester`

## Requirements
- R1: A bit position counter runs over CHANNELS x 8 positions, where CHANNELS is 2^CHAN_W. A position is counted only on cycles with `bitEn` high. When `bitEn` and `frameSync` are both high, that bit is position 0. Otherwise each strobed bit takes the position after the previous one, wrapping at the end of the frame. Channel c covers positions 8c to 8c+7.
- R2: Channel c lies in the transmit window when ((c - txStartCh) mod CHANNELS) <= txExtraCh. The window therefore holds txExtraCh+1 channels and may wrap past the last channel into channel 0. A full frame of 256 channels is possible.
- R3: `serOut` resets to 1. On each cycle with `bitEn` high, the clock edge loads `serOut` with that bit's value. The value is the PRBS bit when `txEnable` is high and the channel is in the transmit window, and 1 otherwise. `serOut` holds its value on cycles without `bitEn`.
- R4: The sequence length is set by `polySel`: 0 selects W=15 and 1 selects W=23. The seed is 23'h3A5C71, and its low 15 bits are 15'h5C71. The first W transmitted bits are the seed, most significant bit first. Each later bit o[k] is o[k-15] xor o[k-14] when W=15, and o[k-23] xor o[k-18] when W=23. The sequence advances only on bits that are sent in the window.
- R5: While `txEnable` stays high, the sequence continues across frames. A low `txEnable` resets the sequence, so the next enabled window bit is again the first seed bit.
- R6: The receive window follows the rule of R2, using `rxStartCh` and `rxExtraCh`. It is independent of the transmit window.
- R7: With `rxEnable` high, the receiver collects the window bits of `serIn`. `rxLocked` rises one clock after the bit that makes the last W collected bits equal the W-bit seed. No error is counted while unlocked.
- R8: Once locked, each receive-window bit is compared with the next value of a local reference sequence. The reference follows the recurrence of R4 from the seed, independently of the received bits. Each mismatch raises `errCount` by exactly one, one clock after that bit.
- R9: `errCount` is 16 bits wide and holds at 16'hFFFF once it gets there.
- R10: While `rxEnable` is low, `rxLocked` is 0 and `errCount` is 0 from the next clock on.
- R11: `serIn` bits outside the receive window, or with `rxEnable` low, affect neither lock nor count.
- R12: Cycles with `bitEn` low advance neither the position, nor a sequence, nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | Strobe marking a cycle that carries one serial bit |
| frameSync | input | 1 | With bitEn, marks the first bit of a frame |
| serIn | input | 1 | Incoming serial bit |
| txEnable | input | 1 | Transmit enable |
| rxEnable | input | 1 | Receive enable; low clears lock and count |
| polySel | input | 1 | 0 for the 15-bit sequence, 1 for the 23-bit sequence |
| txStartCh | input | CHAN_W | First channel of the transmit window |
| txExtraCh | input | CHAN_W | Channels in the transmit window after the first |
| rxStartCh | input | CHAN_W | First channel of the receive window |
| rxExtraCh | input | CHAN_W | Channels in the receive window after the first |
| serOut | output | 1 | Outgoing serial bit, registered |
| rxLocked | output | 1 | Receiver has found the seed |
| errCount | output | CNT_W | Saturating count of mismatched bits |

## Verification
The bound assertions watch the invariants that hold on every cycle:
- idle ones while transmit is disabled;
- `serOut`, lock and count frozen on cycles without `bitEn`;
- a count that never moves while unlocked, rises by at most one per clock and sticks at all ones;
- lock that holds while enabled;
- the clear that follows a low `rxEnable`.

Only the bench scenarios can show the sequence itself, because that takes a bit-by-bit model. These scenarios cover:
- the seed-first sequence order for both lengths;
- window placement, including wrap past the last channel;
- sequence continuity across frames and across bit-strobe gaps;
- restart after a transmit disable;
- realignment by an early `frameSync`;
- no lock on random data before the seed;
- exact error totals under injected flips.

// File: rtl/berPkg.sv
package berPkg;

  localparam int SHORT_W   = 15;
  localparam int LONG_W    = 23;
  localparam int SHORT_TAP = 13;
  localparam int LONG_TAP  = 17;
  localparam logic [LONG_W-1:0] SEED = 23'h3A5C71;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic outLoad;  // a bit slot occurs this cycle
    logic txStep;   // transmit bit is in window: send PRBS and advance
    logic txSeed;   // transmit disabled: hold generator at seed
    logic rxStep;   // receive bit is in window
    logic rxClear;  // receive disabled: drop lock and count
  } berStrobes_t;

  function automatic logic fbBit(input logic [LONG_W-1:0] s, input logic longSel);
    return longSel ? (s[LONG_W-1] ^ s[LONG_TAP]) : (s[SHORT_W-1] ^ s[SHORT_TAP]);
  endfunction

  function automatic logic headBit(input logic [LONG_W-1:0] s, input logic longSel);
    return longSel ? s[LONG_W-1] : s[SHORT_W-1];
  endfunction

  function automatic logic seedMatch(input logic [LONG_W-1:0] s, input logic longSel);
    return longSel ? (s == SEED) : (s[SHORT_W-1:0] == SEED[SHORT_W-1:0]);
  endfunction

endpackage

// File: rtl/berWindow.sv
module berWindow #(
  parameter int CHAN_W = 8
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic [CHAN_W-1:0] startCh,
  input  logic [CHAN_W-1:0] extraCh,
  output logic              hit
);
  logic [CHAN_W-1:0] offset;

  // modulo distance from the start channel; wraps past the last channel
  assign offset = chan - startCh;
  assign hit    = (offset <= extraCh);
endmodule

// File: rtl/berCtrl.sv
module berCtrl
  import berPkg::*;
#(
  parameter int CHAN_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              frameSync,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic [CHAN_W-1:0] txStartCh,
  input  logic [CHAN_W-1:0] txExtraCh,
  input  logic [CHAN_W-1:0] rxStartCh,
  input  logic [CHAN_W-1:0] rxExtraCh,
  output berStrobes_t       strobes
);
  localparam int POS_W  = CHAN_W + BIT_W;
  localparam int N_WIN  = 2;
  localparam int TX_IDX = 0;
  localparam int RX_IDX = 1;

  logic [POS_W-1:0]  posReg;
  logic [POS_W-1:0]  curPos;
  logic [CHAN_W-1:0] curChan;
  logic [CHAN_W-1:0] winStart [N_WIN];
  logic [CHAN_W-1:0] winExtra [N_WIN];
  logic              winHit   [N_WIN];

  // position of the bit offered this cycle
  assign curPos  = (bitEn && frameSync) ? '0 : posReg;
  assign curChan = curPos[POS_W-1:BIT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      posReg <= '0;
    else if (bitEn) posReg <= curPos + 1'b1;
  end

  assign winStart[TX_IDX] = txStartCh;
  assign winExtra[TX_IDX] = txExtraCh;
  assign winStart[RX_IDX] = rxStartCh;
  assign winExtra[RX_IDX] = rxExtraCh;

  for (genvar w = 0; w < N_WIN; w++) begin : gWin
    berWindow #(.CHAN_W(CHAN_W)) u_win (
      .chan    (curChan),
      .startCh (winStart[w]),
      .extraCh (winExtra[w]),
      .hit     (winHit[w])
    );
  end

  always_comb begin
    strobes.outLoad = bitEn;
    strobes.txStep  = bitEn && txEnable && winHit[TX_IDX];
    strobes.txSeed  = !txEnable;
    strobes.rxStep  = bitEn && rxEnable && winHit[RX_IDX];
    strobes.rxClear = !rxEnable;
  end
endmodule

// File: rtl/berDatapath.sv
module berDatapath
  import berPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  berStrobes_t      strobes,
  input  logic             polySel,
  input  logic             serIn,
  output logic             serOut,
  output logic             rxLocked,
  output logic [CNT_W-1:0] errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [LONG_W-1:0] txState;
  logic [LONG_W-1:0] rxShift;
  logic [LONG_W-1:0] rxShiftIn;
  logic              refBit;

  // transmit generator: head bit is the next bit to send
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txState <= SEED;
    else if (strobes.txSeed) txState <= SEED;
    else if (strobes.txStep) txState <= {txState[LONG_W-2:0], fbBit(txState, polySel)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                serOut <= 1'b1;
    else if (strobes.outLoad) serOut <= strobes.txStep ? headBit(txState, polySel) : 1'b1;
  end

  // receiver: history of received bits until lock, then a free-running reference
  assign rxShiftIn = {rxShift[LONG_W-2:0], serIn};
  assign refBit    = fbBit(rxShift, polySel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      rxLocked <= 1'b0;
      errCount <= '0;
    end else if (strobes.rxClear) begin
      rxShift  <= '0;
      rxLocked <= 1'b0;
      errCount <= '0;
    end else if (strobes.rxStep) begin
      if (!rxLocked) begin
        rxShift <= rxShiftIn;
        if (seedMatch(rxShiftIn, polySel)) rxLocked <= 1'b1;
      end else begin
        rxShift <= {rxShift[LONG_W-2:0], refBit};
        if ((serIn != refBit) && (errCount != CNT_MAX)) errCount <= errCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/berTester.sv
module berTester
  import berPkg::*;
#(
  parameter int CHAN_W = 8,
  parameter int BIT_W  = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              frameSync,
  input  logic              serIn,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              polySel,
  input  logic [CHAN_W-1:0] txStartCh,
  input  logic [CHAN_W-1:0] txExtraCh,
  input  logic [CHAN_W-1:0] rxStartCh,
  input  logic [CHAN_W-1:0] rxExtraCh,
  output logic              serOut,
  output logic              rxLocked,
  output logic [CNT_W-1:0]  errCount
);
  berStrobes_t strobes;

  berCtrl #(.CHAN_W(CHAN_W), .BIT_W(BIT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .frameSync (frameSync),
    .txEnable  (txEnable),
    .rxEnable  (rxEnable),
    .txStartCh (txStartCh),
    .txExtraCh (txExtraCh),
    .rxStartCh (rxStartCh),
    .rxExtraCh (rxExtraCh),
    .strobes   (strobes)
  );

  berDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .polySel  (polySel),
    .serIn    (serIn),
    .serOut   (serOut),
    .rxLocked (rxLocked),
    .errCount (errCount)
  );
endmodule

// File: rtl/berTesterChk.sv
module berTesterChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitEn,
  input logic             txEnable,
  input logic             rxEnable,
  input logic             serOut,
  input logic             rxLocked,
  input logic [CNT_W-1:0] errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_idle_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !txEnable) |=> serOut);

  assert_hold_no_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && rxEnable) |=> ($stable(serOut) && $stable(errCount) && $stable(rxLocked)));

  assert_no_count_unlocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && !rxLocked) |=> $stable(errCount));

  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && rxLocked) |=> rxLocked);

  assert_step_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable |=> (errCount == $past(errCount) || errCount == $past(errCount) + 1'b1));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && errCount == CNT_MAX) |=> (errCount == CNT_MAX));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (errCount == '0 && !rxLocked));
endmodule

bind berTester berTesterChk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .bitEn    (bitEn),
  .txEnable (txEnable),
  .rxEnable (rxEnable),
  .serOut   (serOut),
  .rxLocked (rxLocked),
  .errCount (errCount)
);

// File: tb/berTester_tb.sv
module berTester_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CHAN_W = 8;
  localparam int BIT_W  = 3;
  localparam int CNT_W  = 16;
  localparam int POS_W  = CHAN_W + BIT_W;
  localparam int FRAME  = 1 << POS_W;
  localparam logic [22:0] SEED23 = 23'h3A5C71;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, frameSync = 1'b0, serIn = 1'b0;
  logic txEnable = 1'b0, rxEnable = 1'b0, polySel = 1'b0;
  logic [CHAN_W-1:0] txStartCh = '0, txExtraCh = '0, rxStartCh = '0, rxExtraCh = '0;
  logic serOut, rxLocked;
  logic [CNT_W-1:0] errCount;

  int checks = 0;
  int errors = 0;
  string curTag = "R3 R10";

  // bench model state
  logic [POS_W-1:0] benchPos = '0;
  int          txK = 0, rxK = 0;
  logic [22:0] txHist = '0, rxHist = '0, rxSeen = '0;
  logic        expOut = 1'b1, expLock = 1'b0;
  logic [CNT_W-1:0] expCnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  berTester #(.CHAN_W(CHAN_W), .BIT_W(BIT_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync), .serIn(serIn),
    .txEnable(txEnable), .rxEnable(rxEnable), .polySel(polySel),
    .txStartCh(txStartCh), .txExtraCh(txExtraCh), .rxStartCh(rxStartCh), .rxExtraCh(rxExtraCh),
    .serOut(serOut), .rxLocked(rxLocked), .errCount(errCount)
  );

  // R4: seed first (msb first), then the two-tap recurrence on past outputs
  function automatic logic genBit(input int k, input logic [22:0] h, input logic p);
    int w = p ? 23 : 15;
    if (k < w) return SEED23[w-1-k];
    return p ? (h[22] ^ h[17]) : (h[14] ^ h[13]);
  endfunction

  function automatic logic seedHit(input logic [22:0] s, input logic p);
    return p ? (s == SEED23) : (s[14:0] == SEED23[14:0]);
  endfunction

  // R2 and R6 window rule
  function automatic logic inWin(input logic [CHAN_W-1:0] c, input logic [CHAN_W-1:0] st,
                                 input logic [CHAN_W-1:0] ex);
    logic [CHAN_W-1:0] d = c - st;
    return d <= ex;
  endfunction

  task automatic check(input logic ok, input string tag, input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, expv, $time);
    end
  endtask

  // one bit cycle: drive, update model, pass the edge, compare at the falling edge
  task automatic step(input logic be, input logic resync, input int mode, input logic flip);
    logic [CHAN_W-1:0] ch;
    logic b, pred;
    bitEn = be;
    frameSync = 1'b0;
    serIn = 1'($urandom % 2);
    if (!txEnable) begin txK = 0; txHist = '0; end
    if (!rxEnable) begin rxK = 0; rxHist = '0; rxSeen = '0; expLock = 1'b0; expCnt = '0; end
    if (be) begin
      if (resync || benchPos == '0) begin frameSync = 1'b1; benchPos = '0; end
      ch = benchPos[POS_W-1:BIT_W];
      if (txEnable && inWin(ch, txStartCh, txExtraCh)) begin
        b = genBit(txK, txHist, polySel);
        txHist = {txHist[21:0], b};
        txK++;
        expOut = b;
      end else expOut = 1'b1;
      if (rxEnable && inWin(ch, rxStartCh, rxExtraCh)) begin
        if (mode == 1 && !expLock) begin
          rxSeen = {rxSeen[21:0], serIn};
          if (seedHit(rxSeen, polySel)) expLock = 1'b1;
        end else begin
          pred = genBit(rxK, rxHist, polySel);
          rxHist = {rxHist[21:0], pred};
          rxK++;
          b = pred ^ (flip && expLock);
          serIn = b;
          if (!expLock) begin
            rxSeen = {rxSeen[21:0], b};
            if (seedHit(rxSeen, polySel)) expLock = 1'b1;
          end else if (b != pred && expCnt != 16'hFFFF) expCnt++;
        end
      end
      benchPos++;
    end
    @(posedge clk);
    @(negedge clk);
    check(serOut == expOut, {curTag, " serOut"}, int'(serOut), int'(expOut));
    check(rxLocked == expLock, {curTag, " rxLocked"}, int'(rxLocked), int'(expLock));
    check(errCount == expCnt, {curTag, " errCount"}, int'(errCount), int'(expCnt));
  endtask

  task automatic runBits(input int n, input int mode, input int flipPct, input int bePct);
    for (int i = 0; i < n; i++) begin
      logic be = ($urandom_range(99) < bePct);
      step(be, 1'b0, mode, ($urandom_range(99) < flipPct));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R3 R10: reset state
    check(serOut == 1'b1, "R3 reset serOut", int'(serOut), 1);
    check(errCount == '0, "R10 reset errCount", int'(errCount), 0);
    check(rxLocked == 1'b0, "R10 reset rxLocked", int'(rxLocked), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R4 R6 R7 R11: 15-bit sequence, random data before the seed must not lock
    curTag = "R2 R4 R6 R7 R11";
    polySel = 1'b0;
    txStartCh = 8'd5;  txExtraCh = 8'd2;
    rxStartCh = 8'd10; rxExtraCh = 8'd3;
    txEnable = 1'b1; rxEnable = 1'b1;
    runBits(FRAME, 1, 0, 100);
    check(rxLocked == 1'b0, "R7 no lock on random data", int'(rxLocked), 0);
    // R5 R8: continuous across frames, injected flips counted exactly
    curTag = "R5 R8";
    runBits(2 * FRAME, 0, 5, 100);
    check(rxLocked == 1'b1, "R7 locked after seed", int'(rxLocked), 1);
    check(errCount != '0, "R8 flips counted", int'(errCount), int'(expCnt));

    // R2 R6: windows wrapping past the last channel
    curTag = "R2 R6 wrap";
    txEnable = 1'b0; rxEnable = 1'b0;
    step(1'b1, 1'b0, 0, 1'b0);
    txStartCh = 8'd254; txExtraCh = 8'd3;
    rxStartCh = 8'd254; rxExtraCh = 8'd3;
    txEnable = 1'b1; rxEnable = 1'b1;
    runBits(2 * FRAME, 0, 3, 100);

    // R12: bit strobe gaps freeze position and sequences
    curTag = "R12";
    runBits(2 * FRAME, 0, 3, 50);

    // R5: transmit disable restarts at the seed
    curTag = "R5 restart";
    txEnable = 1'b0;
    step(1'b1, 1'b0, 0, 1'b0);
    txEnable = 1'b1;
    runBits(FRAME, 0, 0, 100);

    // R1 R4 R6 R8: random settings, both lengths, early frame realignment
    for (int it = 0; it < 6; it++) begin
      int syncAt;
      curTag = "R1 R4 R6 R8 random";
      txEnable = 1'b0; rxEnable = 1'b0;
      step(1'b1, 1'b0, 0, 1'b0);
      polySel   = (it % 2 == 1);
      txStartCh = CHAN_W'($urandom_range(255));
      txExtraCh = CHAN_W'($urandom_range(255));
      rxStartCh = CHAN_W'($urandom_range(255));
      rxExtraCh = CHAN_W'($urandom_range(40, 2));
      txEnable = 1'b1; rxEnable = 1'b1;
      syncAt = $urandom_range(FRAME - 1, 1);
      for (int i = 0; i < 3 * FRAME; i++)
        step(1'b1, (i == syncAt), 0, ($urandom_range(99) < 4));
      check(rxLocked == 1'b1, "R7 lock after random setup", int'(rxLocked), 1);
    end

    // R9: saturation with every bit flipped, full-frame receive window
    curTag = "R9";
    txEnable = 1'b0; rxEnable = 1'b0;
    step(1'b1, 1'b0, 0, 1'b0);
    polySel = 1'b0;
    rxStartCh = 8'd0; rxExtraCh = 8'd255;
    rxEnable = 1'b1;
    runBits(FRAME, 0, 0, 100);
    runBits(66000, 0, 100, 100);
    check(errCount == 16'hFFFF, "R9 saturated", int'(errCount), 16'hFFFF);

    // R10: disabling the receiver clears lock and count
    curTag = "R10";
    rxEnable = 1'b0;
    step(1'b1, 1'b0, 0, 1'b0);
    check(errCount == '0, "R10 count cleared", int'(errCount), 0);
    check(rxLocked == 1'b0, "R10 lock dropped", int'(rxLocked), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule